// File: doc/BRIEF.md
# Parallel Memory Write-Cycle Capture

This block watches the asynchronous control and bus pins of a byte-wide parallel memory port and turns each genuine write cycle into one clean strobe in the fast sampling clock domain. The active-low chip enable, write enable and output enable are passed through a multi-stage synchronizer. The 20-bit address, the 8-bit data and a supply-good flag travel through the same pipeline, so that all of them stay aligned in time. A write cycle is the interval in which chip enable and write enable are both low.

The address is taken at the first sample of that overlap, which is the moment the later of the two enables falls. The data is taken at the last sample of the overlap, which is the moment before the earlier enable rises. An overlap shorter than a parameterised number of sample cycles is treated as a glitch and dropped. The write is also dropped if output enable is low or the supply-good flag is low at any point during the overlap. A downstream command decoder consumes the resulting one-cycle strobe together with the captured address and data.

Top module: `fwr_capture`

## Requirements
- R1: While reset is applied and in the first cycle after it, `wr_stb` is 0 and `wr_addr` and `wr_data` are all zeros.
- R2: A strobe is produced only by an overlap in which both `ce_n` and `we_n` are low; `we_n` low with `ce_n` high, or `ce_n` low with `we_n` high, produces no strobe.
- R3: `wr_addr` carries the `addr` value present when the later of the two enables fell, even if `addr` changed while only the first enable was low.
- R4: `wr_data` carries the `data` value present just before the earlier of the two enables rose; a data change that coincides with that rising edge is not captured.
- R5: An overlap lasting fewer than `PULSE_MIN_CYC` sample cycles produces no strobe; one lasting exactly `PULSE_MIN_CYC` cycles produces a strobe.
- R6: If `oe_n` is low in any sample of the overlap, no strobe is produced.
- R7: If `supply_ok` is low in any sample of the overlap, no strobe is produced.
- R8: Each qualifying overlap produces exactly one strobe, one cycle wide, however long the overlap lasts.
- R9: `wr_stb` is high during the cycle that begins at the (`SYNC_STAGES`+1)-th rising clock edge after the earlier enable rises.
- R10: With `HOLD_BUS`=1, `wr_addr` and `wr_data` change only together with a strobe and keep their values between strobes, including across rejected pulses.
- R11: An overlap that is already in progress when reset is released is discarded; it produces no strobe when it ends, and later writes are captured normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable pin, active low, asynchronous |
| we_n | input | 1 | Write enable pin, active low, asynchronous |
| oe_n | input | 1 | Output enable pin, active low; low inhibits writes |
| supply_ok | input | 1 | Supply-good flag; low inhibits writes |
| addr | input | ADDR_W (20) | Address bus pins |
| data | input | DATA_W (8) | Data bus pins |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_addr | output | ADDR_W (20) | Captured write address |
| wr_data | output | DATA_W (8) | Captured write data |

## Verification
The assertions assume that every pin, including the buses, stays stable long enough around each enable transition to be sampled by at least one clock edge. They also assume that the bus pins go through the same number of sampling stages as the enables, so that the synchronized overlap and the synchronized buses describe the same instants. The bench changes pins only on falling clock edges and holds each level for whole cycles, so each pin transition lands cleanly in one sample. It changes `addr` or `data` only together with an enable edge, or while the overlap is steadily open, which keeps the stimulus inside these assumptions.

// File: rtl/fwc_pkg.sv
package fwc_pkg;

   // Pulse meter states: DROP waits for the overlap to end without firing.
   typedef enum logic [1:0] {
      MS_DROP = 2'd0,
      MS_IDLE = 2'd1,
      MS_MEAS = 2'd2
   } meter_state_t;

   // Control bundle layout inside the sampling pipeline.
   localparam int CTRL_W   = 4;
   localparam int CTRL_CE  = 0;
   localparam int CTRL_WE  = 1;
   localparam int CTRL_OE  = 2;
   localparam int CTRL_PG  = 3;

   // Post-reset view: enables look asserted, output enable idle, supply bad,
   // so a pulse held through reset is seen as already open and is dropped.
   localparam logic [CTRL_W-1:0] CTRL_RST = 4'b0100;

endpackage

// File: rtl/fwc_sync.sv
module fwc_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  d,
   output logic [W-1:0]  q
);

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/fwc_pulse_meter.sv
module fwc_pulse_meter
   import fwc_pkg::*;
#(
   parameter int MIN_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act,
   input  logic inhib,
   output logic start,
   output logic sample,
   output logic fire
);

   localparam int CW = $clog2(MIN_CYC + 1);
   localparam logic [CW-1:0] CNT_MIN = CW'(MIN_CYC);
   localparam logic [CW-1:0] CNT_ONE = CW'(1);

   meter_state_t st;
   logic [CW-1:0] cnt;

   assign start  = (st == MS_IDLE) && act && !inhib;
   assign sample = act && !inhib && ((st == MS_IDLE) || (st == MS_MEAS));
   assign fire   = (st == MS_MEAS) && !act && (cnt >= CNT_MIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= MS_DROP;
         cnt <= '0;
      end else begin
         unique case (st)
            MS_DROP: begin
               if (!act) st <= MS_IDLE;
            end
            MS_IDLE: begin
               if (act) begin
                  st  <= inhib ? MS_DROP : MS_MEAS;
                  cnt <= CNT_ONE;
               end
            end
            MS_MEAS: begin
               if (act) begin
                  if (inhib) st <= MS_DROP;
                  else if (cnt < CNT_MIN) cnt <= cnt + CNT_ONE;
               end else begin
                  st <= MS_IDLE;
               end
            end
            default: st <= MS_DROP;
         endcase
      end
   end

endmodule

// File: rtl/fwc_latch.sv
module fwc_latch #(
   parameter int ADDR_W   = 20,
   parameter int DATA_W   = 8,
   parameter bit HOLD_BUS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              sample,
   input  logic              fire,
   input  logic [ADDR_W-1:0] addr_d,
   input  logic [DATA_W-1:0] data_d,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);

   logic [ADDR_W-1:0] addr_hold;
   logic [DATA_W-1:0] data_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_hold <= '0;
         data_hold <= '0;
         wr_stb    <= 1'b0;
      end else begin
         if (start)  addr_hold <= addr_d;
         if (sample) data_hold <= data_d;
         wr_stb <= fire;
      end
   end

   generate
      if (HOLD_BUS) begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_addr <= '0;
               wr_data <= '0;
            end else if (fire) begin
               wr_addr <= addr_hold;
               wr_data <= data_hold;
            end
         end
      end else begin : g_mask
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_addr <= '0;
               wr_data <= '0;
            end else begin
               wr_addr <= fire ? addr_hold : '0;
               wr_data <= fire ? data_hold : '0;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/fwr_capture.sv
module fwr_capture
   import fwc_pkg::*;
#(
   parameter int ADDR_W        = 20,
   parameter int DATA_W        = 8,
   parameter int SYNC_STAGES   = 2,
   parameter int PULSE_MIN_CYC = 2,
   parameter bit HOLD_BUS      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic              supply_ok,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);

   localparam int BUS_W  = ADDR_W + DATA_W;
   localparam int PIPE_W = CTRL_W + BUS_W;
   localparam logic [PIPE_W-1:0] PIPE_RST = {CTRL_RST, {BUS_W{1'b0}}};

   generate
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("fwr_capture: SYNC_STAGES must be at least 2");
      end
      if (PULSE_MIN_CYC < 1) begin : g_chk_min
         $error("fwr_capture: PULSE_MIN_CYC must be at least 1");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_chk_w
         $error("fwr_capture: bus widths must be positive");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_raw, ctrl_s;
   logic [PIPE_W-1:0] pipe_q;
   logic [ADDR_W-1:0] addr_d;
   logic [DATA_W-1:0] data_d;

   always_comb begin
      ctrl_raw          = '0;
      ctrl_raw[CTRL_CE] = ce_n;
      ctrl_raw[CTRL_WE] = we_n;
      ctrl_raw[CTRL_OE] = oe_n;
      ctrl_raw[CTRL_PG] = supply_ok;
   end

   fwc_sync #(
      .W       (PIPE_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIPE_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ctrl_raw, addr, data}),
      .q     (pipe_q)
   );

   assign ctrl_s = pipe_q[PIPE_W-1 -: CTRL_W];
   assign addr_d = pipe_q[BUS_W-1 -: ADDR_W];
   assign data_d = pipe_q[DATA_W-1:0];

   logic ce_s, we_s, oe_s, pg_s;
   assign ce_s = ctrl_s[CTRL_CE];
   assign we_s = ctrl_s[CTRL_WE];
   assign oe_s = ctrl_s[CTRL_OE];
   assign pg_s = ctrl_s[CTRL_PG];

   logic act, inhib, start, sample, fire;
   assign act   = !ce_s && !we_s;
   assign inhib = !oe_s || !pg_s;

   fwc_pulse_meter #(
      .MIN_CYC (PULSE_MIN_CYC)
   ) u_meter (
      .clk    (clk),
      .rst_n  (rst_n),
      .act    (act),
      .inhib  (inhib),
      .start  (start),
      .sample (sample),
      .fire   (fire)
   );

   fwc_latch #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .HOLD_BUS (HOLD_BUS)
   ) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .sample  (sample),
      .fire    (fire),
      .addr_d  (addr_d),
      .data_d  (data_d),
      .wr_stb  (wr_stb),
      .wr_addr (wr_addr),
      .wr_data (wr_data)
   );

endmodule

// File: rtl/fwc_checker.sv
module fwc_checker #(
   parameter int ADDR_W        = 20,
   parameter int DATA_W        = 8,
   parameter int PULSE_MIN_CYC = 2,
   parameter bit HOLD_BUS      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_s,
   input  logic              we_s,
   input  logic              oe_s,
   input  logic              pg_s,
   input  logic              fire,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data
);

   localparam int LW = $clog2(PULSE_MIN_CYC + 1) + 1;
   localparam logic [LW-1:0] LEN_MAX = {LW{1'b1}};
   localparam logic [LW-1:0] LEN_MIN = LW'(PULSE_MIN_CYC);

   logic          ov, ov_q, oe_bad_q, pg_bad_q;
   logic [LW-1:0] len_q;

   assign ov = !ce_s && !we_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ov_q     <= 1'b0;
         len_q    <= '0;
         oe_bad_q <= 1'b0;
         pg_bad_q <= 1'b0;
      end else begin
         ov_q <= ov;
         if (ov && !ov_q) begin
            len_q    <= LW'(1);
            oe_bad_q <= !oe_s;
            pg_bad_q <= !pg_s;
         end else if (ov) begin
            if (len_q != LEN_MAX) len_q <= len_q + LW'(1);
            oe_bad_q <= oe_bad_q || !oe_s;
            pg_bad_q <= pg_bad_q || !pg_s;
         end else begin
            len_q    <= '0;
            oe_bad_q <= 1'b0;
            pg_bad_q <= 1'b0;
         end
      end
   end

   assert_fire_at_overlap_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> (ov_q && !ov));

   assert_min_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> (len_q >= LEN_MIN));

   assert_oe_inhibit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> !oe_bad_q);

   assert_supply_inhibit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> !pg_bad_q);

   assert_strobe_follows_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> wr_stb);

   assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   generate
      if (HOLD_BUS) begin : g_hold_chk
         assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !fire |=> ($stable(wr_addr) && $stable(wr_data)));
      end else begin : g_mask_chk
         assert_bus_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_stb |-> (wr_addr == '0 && wr_data == '0));
      end
   endgenerate

endmodule

bind fwr_capture fwc_checker #(
   .ADDR_W        (ADDR_W),
   .DATA_W        (DATA_W),
   .PULSE_MIN_CYC (PULSE_MIN_CYC),
   .HOLD_BUS      (HOLD_BUS)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ce_s    (ce_s),
   .we_s    (we_s),
   .oe_s    (oe_s),
   .pg_s    (pg_s),
   .fire    (fire),
   .wr_stb  (wr_stb),
   .wr_addr (wr_addr),
   .wr_data (wr_data)
);

// File: tb/fwr_capture_tb.sv
module fwr_capture_tb;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 20;
   localparam int DW         = 8;
   localparam int SYNC       = 2;
   localparam int MIN_CYC    = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          ce_n, we_n, oe_n, supply_ok;
   logic [AW-1:0] addr;
   logic [DW-1:0] data;
   logic          wr_stb;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;

   int n_chk  = 0;
   int n_fail = 0;
   int n_stb  = 0;
   logic [AW-1:0] last_addr;
   logic [DW-1:0] last_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   fwr_capture #(
      .ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SYNC),
      .PULSE_MIN_CYC(MIN_CYC), .HOLD_BUS(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .supply_ok(supply_ok), .addr(addr), .data(data),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   always @(negedge clk) begin
      if (rst_n && wr_stb) begin
         n_stb     <= n_stb + 1;
         last_addr <= wr_addr;
         last_data <= wr_data;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic idle_pins();
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; supply_ok = 1'b1;
   endtask

   task automatic pulse(input logic [AW-1:0] a, input logic [DW-1:0] d, input int len);
      @(negedge clk);
      addr = a; data = d; ce_n = 1'b0; we_n = 1'b0;
      cyc(len);
      ce_n = 1'b1; we_n = 1'b1;
      cyc(8);
   endtask

   task automatic t_reset();
      check(wr_stb == 1'b0, "R1 stb", 32'(wr_stb), 0);
      check(wr_addr == '0, "R1 addr", 32'(wr_addr), 0);
      check(wr_data == '0, "R1 data", 32'(wr_data), 0);
   endtask

   task automatic t_latency();
      int base;
      base = n_stb;
      @(negedge clk);
      addr = 20'h12345; data = 8'hA5; ce_n = 1'b0; we_n = 1'b0;
      cyc(3);
      ce_n = 1'b1; we_n = 1'b1;
      @(negedge clk); check(wr_stb == 1'b0, "R9 edge1", 32'(wr_stb), 0);
      @(negedge clk); check(wr_stb == 1'b0, "R9 edge2", 32'(wr_stb), 0);
      @(negedge clk); check(wr_stb == 1'b1, "R9 edge3", 32'(wr_stb), 1);
      check(wr_addr == 20'h12345, "R9 addr", 32'(wr_addr), 32'h12345);
      check(wr_data == 8'hA5, "R9 data", 32'(wr_data), 32'hA5);
      @(negedge clk); check(wr_stb == 1'b0, "R8 one cycle", 32'(wr_stb), 0);
      cyc(4);
      check(n_stb - base == 1, "R8 count basic", 32'(n_stb - base), 1);
   endtask

   task automatic t_width();
      int base;
      base = n_stb;
      pulse(20'h00111, 8'h11, MIN_CYC - 1);
      check(n_stb - base == 0, "R5 short", 32'(n_stb - base), 0);
      check(wr_addr == 20'h12345, "R10 hold after reject", 32'(wr_addr), 32'h12345);
      pulse(20'h00222, 8'h22, MIN_CYC);
      check(n_stb - base == 1, "R5 exact", 32'(n_stb - base), 1);
      check(last_addr == 20'h00222 && last_data == 8'h22, "R5 value", 32'(last_addr), 32'h00222);
   endtask

   task automatic t_single_enable();
      int base;
      base = n_stb;
      @(negedge clk); addr = 20'h0AAAA; data = 8'h5A; we_n = 1'b0;
      cyc(6); we_n = 1'b1; cyc(8);
      check(n_stb - base == 0, "R2 we only", 32'(n_stb - base), 0);
      @(negedge clk); ce_n = 1'b0;
      cyc(6); ce_n = 1'b1; cyc(8);
      check(n_stb - base == 0, "R2 ce only", 32'(n_stb - base), 0);
   endtask

   task automatic t_addr_late();
      int base;
      base = n_stb;
      @(negedge clk); addr = 20'h11111; data = 8'h00; ce_n = 1'b0;
      cyc(3);
      addr = 20'h76543; we_n = 1'b0;
      cyc(4);
      we_n = 1'b1; cyc(1); ce_n = 1'b1; cyc(8);
      check(n_stb - base == 1, "R3 count", 32'(n_stb - base), 1);
      check(last_addr == 20'h76543, "R3 addr", 32'(last_addr), 32'h76543);
   endtask

   task automatic t_data_early();
      int base;
      base = n_stb;
      @(negedge clk); addr = 20'h0BEEF; data = 8'h01; ce_n = 1'b0; we_n = 1'b0;
      cyc(2); data = 8'h3C;
      cyc(2); data = 8'hC3; we_n = 1'b1;
      cyc(2); ce_n = 1'b1; data = 8'hFF;
      cyc(8);
      check(n_stb - base == 1, "R4 count", 32'(n_stb - base), 1);
      check(last_data == 8'h3C, "R4 data", 32'(last_data), 32'h3C);
   endtask

   task automatic t_oe_inhibit();
      int base;
      base = n_stb;
      oe_n = 1'b0;
      pulse(20'h00333, 8'h33, 5);
      oe_n = 1'b1;
      check(n_stb - base == 0, "R6 oe low whole", 32'(n_stb - base), 0);
      @(negedge clk); addr = 20'h00444; ce_n = 1'b0; we_n = 1'b0;
      cyc(2); oe_n = 1'b0; cyc(1); oe_n = 1'b1; cyc(3);
      ce_n = 1'b1; we_n = 1'b1; cyc(8);
      check(n_stb - base == 0, "R6 oe blip", 32'(n_stb - base), 0);
   endtask

   task automatic t_supply();
      int base;
      base = n_stb;
      @(negedge clk); addr = 20'h00555; ce_n = 1'b0; we_n = 1'b0;
      cyc(2); supply_ok = 1'b0; cyc(1); supply_ok = 1'b1; cyc(3);
      ce_n = 1'b1; we_n = 1'b1; cyc(8);
      check(n_stb - base == 0, "R7 supply dip", 32'(n_stb - base), 0);
      supply_ok = 1'b0;
      pulse(20'h00666, 8'h66, 4);
      supply_ok = 1'b1;
      check(n_stb - base == 0, "R7 supply low", 32'(n_stb - base), 0);
   endtask

   task automatic t_long();
      int base;
      base = n_stb;
      pulse(20'hFEDCB, 8'h99, 40);
      check(n_stb - base == 1, "R8 long pulse", 32'(n_stb - base), 1);
      cyc(10);
      check(wr_addr == 20'hFEDCB && wr_data == 8'h99, "R10 hold idle", 32'(wr_addr), 32'hFEDCB);
   endtask

   task automatic t_reset_midpulse();
      int base;
      @(negedge clk); addr = 20'h0F0F0; data = 8'hF0; ce_n = 1'b0; we_n = 1'b0;
      cyc(3); rst_n = 1'b0; cyc(3); rst_n = 1'b1;
      base = n_stb;
      cyc(6); ce_n = 1'b1; we_n = 1'b1; cyc(8);
      check(n_stb - base == 0, "R11 discard", 32'(n_stb - base), 0);
      pulse(20'h0ABCD, 8'h42, 3);
      check(n_stb - base == 1, "R11 recover", 32'(n_stb - base), 1);
      check(last_addr == 20'h0ABCD, "R11 addr", 32'(last_addr), 32'h0ABCD);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_fail++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      rst_n = 1'b0;
      idle_pins();
      addr = '0; data = '0;
      cyc(4);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      cyc(4);
      t_latency();
      t_width();
      t_single_enable();
      t_addr_late();
      t_data_early();
      t_oe_inhibit();
      t_supply();
      t_long();
      t_reset_midpulse();
      report();
   end

endmodule